// File: doc/BRIEF.md
# Lockstep Serial-to-Parallel Receiver

This block turns a serial bit stream, sampled on a fast bit clock, into parallel words presented on a divided clock. The divided clock runs at the bit clock divided by the word width, and its rising edges line up with bit-clock rising edges. Serial bits fill the word oldest-first, so the first bit of a word lands in the most significant position.

The reset input clears every data flop at once, in both clock domains, without waiting for a clock edge. Leaving reset is handled separately in each domain. A short synchronizer on the divided clock decides the release edge. The bit-clock logic then follows that decision one bit-clock edge later. Several copies that share one reset pulse therefore frame their words on the same bit and leave reset on the same divided-clock edge, even when routing skew makes the pulse fall in different bit-clock cycles at each copy.

A mode input picks one of two capture paths. In networking mode the captured bit goes straight into the shift register and the free-running clock input is unused and tied low. In memory mode each captured bit passes through one flop on a free-running clock of the same frequency before it is shifted. This moves strobe-timed data into a steady clock domain.

Top module: `deser_lockstep_rx`

## Requirements
- R1: Raising `rst_in` forces `par_word` to zero and `word_valid` low at once, with no clock edge needed, and they stay so while `rst_in` is high.
- R2: A reset pulse that spans a single divided-clock rising edge is enough for a complete reset and release sequence.
- R3: The divided-domain reset is released on the second divided-clock rising edge after `rst_in` falls.
- R4: The bit-clock-domain reset is released on the first bit-clock rising edge after the divided-domain release, so that the first word after reset is complete and correctly framed.
- R5: In networking mode (`mem_mode` = 0), the word loaded on the divided edge that coincides with bit-clock edge number t holds the bits presented before bit-clock edges t-WIDTH-1 through t-2, the earliest in bit WIDTH-1.
- R6: In memory mode (`mem_mode` = 1, with `clk_free` at the bit-clock frequency), each bit passes through one extra `clk_free` flop, so the word holds the bits presented before edges t-WIDTH-2 through t-3, the earliest in bit WIDTH-1.
- R7: Counting divided-clock rising edges after `rst_in` falls, `par_word` stays zero and `word_valid` stays low through the third edge. The first word and `word_valid` high appear on the fourth edge.
- R8: Once `word_valid` is high, it stays high until the next reset, and a new word is loaded on every divided-clock rising edge.
- R9: Two instances with a shared clock, whose reset inputs fall at different bit-clock cycles within the same divided-clock period, show identical `par_word` and `word_valid` on every divided-clock edge.
- R10: Whenever `word_valid` is low, `par_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit clock; samples the serial input |
| clk_div | input | 1 | Word clock; bit clock divided by WIDTH, rising edges aligned |
| clk_free | input | 1 | Free-running transfer clock for memory mode; tied low in networking mode |
| rst_in | input | 1 | Active-high reset; asserts asynchronously, must span one word-clock edge |
| mem_mode | input | 1 | 0 = networking capture path, 1 = memory capture path; change only in reset |
| ser_in | input | 1 | Serial data bit |
| par_word | output | WIDTH | Parallel word, earliest bit in the MSB |
| word_valid | output | 1 | High while `par_word` carries a received word |

## Verification
The hardest case to reach is two copies whose reset falls in different bit-clock cycles, while still landing inside the same word-clock period. Only then does the release logic have to absorb the skew. The bench lines each reset release up with a word-clock edge and then lets each copy's reset fall independently, one to three bit cycles later. It includes one pulse that covers only a single word-clock edge, and one reset that switches the capture path. After each release it compares both copies against a bit-history model on every word edge, from the zero-output window through the first valid word.

// File: rtl/deser_pkg.sv
package deser_pkg;

  typedef enum logic {
    MODE_NET = 1'b0,
    MODE_MEM = 1'b1
  } deser_mode_e;

  localparam int WIDTH_MIN = 2;
  localparam int WIDTH_MAX = 8;

endpackage

// File: rtl/deser_rst_retime.sv
module deser_rst_retime #(
  parameter int STAGES = 2
) (
  input  logic clk_div,
  input  logic clk_fast,
  input  logic rst_in,
  output logic rst_div,
  output logic rst_fast
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic         fast_q;

  // Divided-domain release: a chain that clears one stage per word edge
  always_ff @(posedge clk_div or posedge rst_in) begin
    if (rst_in) sync_q <= '1;
    else        sync_q <= {sync_q[TOP-1:0], 1'b0};
  end

  assign rst_div = sync_q[TOP];

  // Bit-clock release trails the divided release by one bit edge
  always_ff @(posedge clk_fast or posedge rst_in) begin
    if (rst_in) fast_q <= 1'b1;
    else        fast_q <= rst_div;
  end

  assign rst_fast = fast_q;

  // R3: divided release only after rst_in has been low for two word edges
  p_div_release_r3: assert property (@(posedge clk_div) disable iff (rst_in)
    $fell(rst_div) |-> (!$past(rst_in) && !$past(rst_in, 2)));

  // R4: bit-clock release follows the divided release by exactly one bit edge
  p_fast_follows_div_r4: assert property (@(posedge clk_fast) disable iff (rst_in)
    $fell(rst_fast) |-> (!$past(rst_div) && $past(rst_div, 2)));

endmodule

// File: rtl/deser_capture.sv
module deser_capture
  import deser_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_fast,
  input  logic             clk_free,
  input  logic             rst_in,
  input  logic             rst_fast,
  input  deser_mode_e      mode,
  input  logic             ser_in,
  output logic [WIDTH-1:0] shift_word
);

  logic cap_q;
  logic xfer_q;
  logic in_bit;
  logic [WIDTH-1:0] sh_q;

  // Capture flop on the bit clock
  always_ff @(posedge clk_fast or posedge rst_in) begin
    if (rst_in)        cap_q <= 1'b0;
    else if (rst_fast) cap_q <= 1'b0;
    else               cap_q <= ser_in;
  end

  // Transfer flop onto the free-running clock (memory path)
  always_ff @(posedge clk_free or posedge rst_in) begin
    if (rst_in)        xfer_q <= 1'b0;
    else if (rst_fast) xfer_q <= 1'b0;
    else               xfer_q <= cap_q;
  end

  assign in_bit = (mode == MODE_MEM) ? xfer_q : cap_q;

  // Shift register: new bit enters at bit 0, older bits move toward the MSB
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = in_bit;
    end else begin : g_body
      assign nxt = sh_q[i-1];
    end
    always_ff @(posedge clk_fast or posedge rst_in) begin
      if (rst_in)        sh_q[i] <= 1'b0;
      else if (rst_fast) sh_q[i] <= 1'b0;
      else               sh_q[i] <= nxt;
    end
  end

  assign shift_word = sh_q;

  // R5: after a shifting edge, every bit has moved one place toward the MSB
  p_shift_order_r5: assert property (@(posedge clk_fast) disable iff (rst_in)
    !$past(rst_fast) |-> (shift_word[WIDTH-1:1] == $past(shift_word[WIDTH-2:0])));

endmodule

// File: rtl/deser_word_out.sv
module deser_word_out #(
  parameter int WIDTH = 4
) (
  input  logic             clk_div,
  input  logic             rst_in,
  input  logic             rst_div,
  input  logic [WIDTH-1:0] shift_word,
  output logic [WIDTH-1:0] word,
  output logic             valid
);

  logic             primed_q;
  logic [WIDTH-1:0] word_q;
  logic             valid_q;

  always_ff @(posedge clk_div or posedge rst_in) begin
    if (rst_in) begin
      primed_q <= 1'b0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else if (rst_div) begin
      primed_q <= 1'b0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      if (primed_q) begin
        word_q  <= shift_word;
        valid_q <= 1'b1;
      end
    end
  end

  assign word  = word_q;
  assign valid = valid_q;

  // R7: the first valid word comes at least two word edges after the divided release
  p_first_word_delay_r7: assert property (@(posedge clk_div) disable iff (rst_in)
    $rose(valid) |-> (!$past(rst_div) && !$past(rst_div, 2)));

  // R8: valid holds until the next reset
  p_valid_sticky_r8: assert property (@(posedge clk_div) disable iff (rst_in)
    valid |=> valid);

  // R10: no data leaks out while the word is not valid
  p_zero_when_idle_r10: assert property (@(posedge clk_div) disable iff (rst_in)
    !valid |-> (word == '0));

endmodule

// File: rtl/deser_lockstep_rx.sv
module deser_lockstep_rx
  import deser_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk_fast,
  input  logic             clk_div,
  input  logic             clk_free,
  input  logic             rst_in,
  input  logic             mem_mode,
  input  logic             ser_in,
  output logic [WIDTH-1:0] par_word,
  output logic             word_valid
);

  logic             rst_div;
  logic             rst_fast;
  logic [WIDTH-1:0] shift_word;
  deser_mode_e      mode;

  assign mode = deser_mode_e'(mem_mode);

  deser_rst_retime #(
    .STAGES (SYNC_DEPTH)
  ) u_retime (
    .clk_div  (clk_div),
    .clk_fast (clk_fast),
    .rst_in   (rst_in),
    .rst_div  (rst_div),
    .rst_fast (rst_fast)
  );

  deser_capture #(
    .WIDTH (WIDTH)
  ) u_capture (
    .clk_fast   (clk_fast),
    .clk_free   (clk_free),
    .rst_in     (rst_in),
    .rst_fast   (rst_fast),
    .mode       (mode),
    .ser_in     (ser_in),
    .shift_word (shift_word)
  );

  deser_word_out #(
    .WIDTH (WIDTH)
  ) u_word_out (
    .clk_div    (clk_div),
    .rst_in     (rst_in),
    .rst_div    (rst_div),
    .shift_word (shift_word),
    .word       (par_word),
    .valid      (word_valid)
  );

  // R1: reset holds the outputs cleared
  p_reset_clears_r1: assert property (@(posedge clk_fast)
    rst_in |-> (par_word == '0 && !word_valid));

endmodule

// File: tb/deser_lockstep_rx_bench.sv
module deser_lockstep_rx_bench;

  localparam int W  = 4;
  localparam int HB = 1024;

  logic clk_fast = 1'b0;
  logic clk_div  = 1'b0;
  logic clk_free;
  logic rst_a    = 1'b0;
  logic rst_b    = 1'b0;
  logic mem_sel  = 1'b0;
  logic ser      = 1'b0;
  logic [W-1:0] word_a, word_b;
  logic val_a, val_b;

  int   fidx   = -1;
  logic hist [HB];
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  int   rel_d  = 0;
  int   pat    = 0;
  bit   done   = 1'b0;

  assign clk_free = mem_sel ? clk_fast : 1'b0;

  // 250 MHz bit clock, word clock rising with every W-th bit edge
  always begin
    #2;
    fidx++;
    clk_fast = 1'b1;
    if (fidx % W == 0)     clk_div = 1'b1;
    if (fidx % W == W / 2) clk_div = 1'b0;
    #2;
    clk_fast = 1'b0;
  end

  deser_lockstep_rx #(.WIDTH(W)) u_deser_lockstep_rx (
    .clk_fast (clk_fast), .clk_div (clk_div), .clk_free (clk_free),
    .rst_in (rst_a), .mem_mode (mem_sel), .ser_in (ser),
    .par_word (word_a), .word_valid (val_a)
  );

  deser_lockstep_rx #(.WIDTH(W)) u_deser_lockstep_rx_b (
    .clk_fast (clk_fast), .clk_div (clk_div), .clk_free (clk_free),
    .rst_in (rst_b), .mem_mode (mem_sel), .ser_in (ser),
    .par_word (word_b), .word_valid (val_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at bit edge %0d", tag, act, exp, fidx);
    end
  endtask

  // Expected word from the bit history (R5 networking, R6 memory)
  function automatic logic [W-1:0] model(input int t, input bit mem);
    logic [W-1:0] w;
    int base;
    base = t - W - 1 - (mem ? 1 : 0);
    for (int i = 0; i < W; i++) w[W-1-i] = hist[(base + i) % HB];
    return w;
  endfunction

  // Serial driver: random and directed patterns, value recorded for the next bit edge
  always @(negedge clk_fast) begin
    logic [31:0] r;
    r = $urandom;
    case (pat)
      0:       ser = r[0];
      1:       ser = 1'b1;
      2:       ser = ~ser;
      default: ser = ((fidx % 7) == 0);
    endcase
    hist[(fidx + 1) % HB] = ser;
  end

  // Monitor on each word edge
  always @(negedge clk_fast) begin
    int t;
    logic [W-1:0] exp;
    t = fidx;
    if (mon_en && t >= 0 && (t % W == 0)) begin
      if (t < rel_d + 4 * W) begin
        // R7 / R10: zero window after release; R3 R4 set its length
        chk(!val_a && word_a == '0, "R7/R10 inst A zero window", {val_a, word_a[W-2:0]}, '0);
        chk(!val_b && word_b == '0, "R7/R10 inst B zero window", {val_b, word_b[W-2:0]}, '0);
      end else begin
        exp = model(t, mem_sel);
        if (t == rel_d + 4 * W) begin
          // R3 R4: first word complete and framed on the fourth word edge
          chk(val_a && word_a == exp, "R3/R4 first word A", word_a, exp);
        end
        chk(val_a == 1'b1, "R8 valid A", {{(W-1){1'b0}}, val_a}, 1);
        chk(word_a == exp, mem_sel ? "R6 memory word A" : "R5 network word A", word_a, exp);
        chk(word_b == exp, mem_sel ? "R6 memory word B" : "R5 network word B", word_b, exp);
      end
      chk(word_a == word_b && val_a == val_b, "R9 lockstep", word_a, word_b);
    end
  end

  task automatic wait_div();
    do @(negedge clk_fast); while (fidx % W != 0);
  endtask

  // Reset both instances; release each ka / kb bit cycles after a word edge
  task automatic do_reset(input int ka, input int kb, input int hold_div, input bit new_mem);
    wait_div();
    mon_en = 1'b0;
    rst_a  = 1'b1;
    rst_b  = 1'b1;
    #1;
    chk(word_a == '0 && !val_a, "R1 async clear A", word_a, '0);
    chk(word_b == '0 && !val_b, "R1 async clear B", word_b, '0);
    mem_sel = new_mem;
    repeat (hold_div) wait_div();
    rel_d  = fidx;
    mon_en = 1'b1;
    for (int j = 0; j < W; j++) begin
      if (j == ka - 1) rst_a = 1'b0;
      if (j == kb - 1) rst_b = 1'b0;
      @(negedge clk_fast);
    end
  endtask

  task automatic run_words(input int p, input int n);
    pat = p;
    repeat (n * W) @(negedge clk_fast);
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd2718));
    #1;
    rst_a = 1'b1;
    rst_b = 1'b1;
    do_reset(1, 1, 3, 1'b0);
    run_words(0, 40);
    run_words(1, 10);
    run_words(2, 10);
    run_words(3, 12);
    // R2: single word-edge reset pulse, skewed release (R9)
    do_reset(1, 3, 1, 1'b0);
    run_words(0, 30);
    do_reset(2, 1, 2, 1'b1);
    run_words(0, 40);
    run_words(2, 10);
    run_words(3, 12);
    for (int k = 0; k < 4; k++) begin
      int ka, kb;
      ka = int'($urandom % 3) + 1;
      kb = int'($urandom % 3) + 1;
      do_reset(ka, kb, 1 + k % 2, k[0]);
      run_words(0, 20);
    end
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk_fast);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

endmodule